// File: doc/BRIEF.md
# Key event register with interrupt

This block sits between a key-matrix scanner and a host. The scanner hands over each confirmed change of the matrix as a batch of event beats. Each beat carries a key code and a pressed flag, and the final beat of the batch is marked. When a batch finishes, the block stores its events and pulls an active-low interrupt line. While the interrupt is pending, further matrix changes are refused, so the stored batch cannot change under the host.

The host reads a single status byte. Bit 7 says more events follow the one shown. Bit 6 is the press flag. Bits 5:0 are the key code. A one-cycle read strobe consumes the shown event and moves to the next one. Events come out lowest key code first, whatever order they arrived in. The read that consumes the final event empties the register and releases the interrupt.

An optional timer releases the interrupt 5 or 10 milliseconds after it was raised, even if the host has not drained the events. The stored events stay readable after that release, until a newer batch replaces them.

The event input is a valid/ready stream. `ev_ready` is held high at all times and the block never applies back-pressure. A beat is consumed on every cycle where `ev_valid` is high. Beats of a batch that is refused are consumed and dropped.

Top module: `key_event_reg`

## Requirements
- R1: `status_byte` is {more, pressed, code}. Bit 7 is 1 exactly when at least one further event remains after the one shown. Bit 6 is 1 for a press and 0 for a release. Bits 5:0 hold the key code. The byte is 0x00 when nothing is stored.
- R2: Each read strobe consumes the event shown, and the byte shows the next stored event from the following cycle. Events appear in strictly ascending key-code order, independent of arrival order.
- R3: A read strobe while bit 7 is 0 and an event is stored empties the register. From the next cycle `status_byte` is 0x00 and `int_n` is high.
- R4: When the final beat of an accepted batch is taken, `int_n` is low from the next cycle, and `status_byte` shows the batch's lowest-coded event.
- R5: A batch whose first beat arrives while `int_n` is low is dropped whole. While `int_n` is low, only read strobes change `status_byte`.
- R6: `aci_mode` selects the auto-release. 2'b01 releases `int_n` after exactly 5*CLKS_PER_MS cycles low. 2'b10 releases it after 10*CLKS_PER_MS cycles. 2'b00 and 2'b11 disable the timer, so only the final read releases the line.
- R7: After an automatic release, the remaining events can still be read in ascending order, and `int_n` stays high during those reads.
- R8: A batch accepted while `int_n` is high replaces all stored events. If a read strobe falls in the cycle that batch commits, the new batch is stored complete and the strobe has no effect.
- R9: `ev_ready` is always 1. A key code repeated within one batch yields one event, and its last beat's press flag is kept.
- R10: After reset, `int_n` is high and `status_byte` is 0x00.
- R11: A read strobe while nothing is stored leaves `status_byte` at 0x00 and `int_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event beat valid |
| ev_ready | output | 1 | Event beat ready, constant 1 |
| ev_code | input | 6 | Key code of the beat |
| ev_press | input | 1 | 1 = key pressed, 0 = released |
| ev_last | input | 1 | Final beat of the batch |
| aci_mode | input | 2 | Auto-release select: 01 short, 10 long, else off |
| rd_strobe | input | 1 | One-cycle read: consume the shown event |
| status_byte | output | 8 | Current event byte |
| int_n | output | 1 | Active-low interrupt |

## Verification
Two functions can collide in one cycle. A batch can commit after an automatic release in the same cycle that the host strobes a read of the old data. The bench lets the short timer expire and pops one old event. It then drives the final beat of a new batch together with `rd_strobe`. The result is correct only if every new event is then read back in order and none of the remaining old events appears.

// File: rtl/kev_pkg.sv
package kev_pkg;
  typedef enum logic [1:0] {
    ACI_OFF   = 2'b00,
    ACI_SHORT = 2'b01,
    ACI_LONG  = 2'b10,
    ACI_RSVD  = 2'b11
  } aci_e;
endpackage

// File: rtl/kev_stage.sv
// Collects the beats of one batch; the accept decision is taken at the first beat.
module kev_stage #(
  parameter int N_KEYS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  input  logic [$clog2(N_KEYS)-1:0] ev_code,
  input  logic                      ev_press,
  input  logic                      ev_last,
  input  logic                      open_i,
  output logic                      batch_go,
  output logic [N_KEYS-1:0]         batch_chg,
  output logic [N_KEYS-1:0]         batch_prs
);
  logic              mid_q, keep_q, keep_now;
  logic [N_KEYS-1:0] chg_q, prs_q, onehot;

  assign keep_now = mid_q ? keep_q : open_i;

  always_comb begin
    onehot          = '0;
    onehot[ev_code] = 1'b1;
    batch_chg       = chg_q | onehot;
    batch_prs       = ev_press ? (prs_q | onehot) : (prs_q & ~onehot);
    batch_go        = ev_valid & ev_last & keep_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      keep_q <= 1'b0;
      chg_q  <= '0;
      prs_q  <= '0;
    end else if (ev_valid) begin
      if (ev_last) begin
        mid_q <= 1'b0;
        chg_q <= '0;
        prs_q <= '0;
      end else begin
        mid_q  <= 1'b1;
        keep_q <= keep_now;
        if (keep_now) begin
          chg_q <= batch_chg;
          prs_q <= batch_prs;
        end
      end
    end
  end
endmodule

// File: rtl/kev_store.sv
// Holds pending events as a mask indexed by key code; the lowest set bit is the head.
module kev_store #(
  parameter int N_KEYS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [N_KEYS-1:0]           ld_chg,
  input  logic [N_KEYS-1:0]           ld_prs,
  input  logic                        pop_req,
  output logic [$clog2(N_KEYS)+1:0]   head_byte,
  output logic                        pop_last
);
  localparam int CW = $clog2(N_KEYS);

  logic [N_KEYS-1:0] pend_q, prs_q;
  logic [CW-1:0]     idx;
  logic              nonempty, more, pop;

  always_comb begin
    idx = '0;
    for (int i = N_KEYS - 1; i >= 0; i--) begin
      if (pend_q[i]) idx = CW'(i);
    end
    nonempty  = |pend_q;
    more      = |(pend_q & (pend_q - 1'b1));
    head_byte = nonempty ? {more, prs_q[idx], idx} : '0;
    pop       = pop_req & nonempty & ~load;
    pop_last  = pop & ~more;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      prs_q  <= '0;
    end else if (load) begin
      pend_q <= ld_chg;
      prs_q  <= ld_prs;
    end else if (pop) begin
      pend_q <= pend_q & (pend_q - 1'b1);
    end
  end
endmodule

// File: rtl/kev_irq.sv
// Active-low interrupt with optional auto-release timer.
module kev_irq
  import kev_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       read_done,
  input  logic [1:0] aci_mode,
  output logic       int_n
);
  localparam int SHORT_CYC = 5 * CLKS_PER_MS;
  localparam int LONG_CYC  = 10 * CLKS_PER_MS;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] cnt_q, limit;
  logic             armed, int_q;

  always_comb begin
    armed = 1'b1;
    limit = '0;
    case (aci_e'(aci_mode))
      ACI_SHORT: limit = CNT_W'(SHORT_CYC - 1);
      ACI_LONG:  limit = CNT_W'(LONG_CYC - 1);
      default:   armed = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b1;
      cnt_q <= '0;
    end else if (load) begin
      int_q <= 1'b0;
      cnt_q <= '0;
    end else if (!int_q) begin
      if (read_done)                   int_q <= 1'b1;
      else if (armed && cnt_q >= limit) int_q <= 1'b1;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  assign int_n = int_q;
endmodule

// File: rtl/key_event_reg.sv
module key_event_reg #(
  parameter int N_KEYS      = 64,
  parameter int CLKS_PER_MS = 50000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  output logic                      ev_ready,
  input  logic [$clog2(N_KEYS)-1:0] ev_code,
  input  logic                      ev_press,
  input  logic                      ev_last,
  input  logic [1:0]                aci_mode,
  input  logic                      rd_strobe,
  output logic [$clog2(N_KEYS)+1:0] status_byte,
  output logic                      int_n
);
  logic              commit, read_done;
  logic [N_KEYS-1:0] b_chg, b_prs;

  assign ev_ready = 1'b1;

  kev_stage #(.N_KEYS(N_KEYS)) i_stage (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_press(ev_press), .ev_last(ev_last), .open_i(int_n),
    .batch_go(commit), .batch_chg(b_chg), .batch_prs(b_prs)
  );

  kev_store #(.N_KEYS(N_KEYS)) i_store (
    .clk(clk), .rst_n(rst_n), .load(commit), .ld_chg(b_chg), .ld_prs(b_prs),
    .pop_req(rd_strobe), .head_byte(status_byte), .pop_last(read_done)
  );

  kev_irq #(.CLKS_PER_MS(CLKS_PER_MS)) i_irq (
    .clk(clk), .rst_n(rst_n), .load(commit), .read_done(read_done),
    .aci_mode(aci_mode), .int_n(int_n)
  );
endmodule

// File: rtl/key_event_reg_chk.sv
module key_event_reg_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_n,
  input logic          rd_strobe,
  input logic [BW-1:0] status_byte,
  input logic [1:0]    aci_mode,
  input logic          load
);
  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n && !rd_strobe |=> $stable(status_byte)); // R5

  AST_LAST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n && rd_strobe && !status_byte[BW-1] |=> (status_byte == '0) && int_n); // R3

  AST_ASCENDING_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && status_byte[BW-1] && !load |=>
      status_byte[BW-3:0] > $past(status_byte[BW-3:0])); // R2

  AST_LOAD_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !int_n); // R4

  AST_NO_TIMER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) && (aci_mode == 2'b00 || aci_mode == 2'b11) |-> $past(rd_strobe)); // R6
endmodule

bind key_event_reg key_event_reg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .int_n(int_n), .rd_strobe(rd_strobe),
  .status_byte(status_byte), .aci_mode(aci_mode), .load(commit)
);

// File: tb/test_key_event_reg.sv
module test_key_event_reg;
  localparam int CPM   = 4;
  localparam int SHORT = 5 * CPM;
  localparam int LONG  = 10 * CPM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0, ev_press = 1'b0, ev_last = 1'b0, rd_strobe = 1'b0;
  logic [5:0] ev_code = '0;
  logic [1:0] aci_mode = 2'b00;
  logic       ev_ready, int_n;
  logic [7:0] status_byte;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] m_chg = '0, m_prs = '0;

  always #10 clk = ~clk;

  key_event_reg #(.N_KEYS(64), .CLKS_PER_MS(CPM)) i_key_event_reg (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .ev_press(ev_press), .ev_last(ev_last),
    .aci_mode(aci_mode), .rd_strobe(rd_strobe), .status_byte(status_byte), .int_n(int_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_head();
    int lo = -1;
    int cnt = 0;
    for (int i = 0; i < 64; i++) begin
      if (m_chg[i]) begin
        if (lo < 0) lo = i;
        cnt++;
      end
    end
    if (lo < 0) return 8'h00;
    return {cnt > 1, m_prs[lo], 6'(lo)};
  endfunction

  task automatic send_batch(input logic [63:0] chg, input logic [63:0] prs,
                            input bit descending, input bit take, input bit rd_at_last);
    int total = $countones(chg);
    int sent = 0;
    for (int k = 0; k < 64; k++) begin
      int i = descending ? 63 - k : k;
      if (chg[i]) begin
        sent++;
        @(negedge clk);
        ev_valid = 1'b1; ev_code = 6'(i); ev_press = prs[i]; ev_last = (sent == total);
        if (sent == total) rd_strobe = rd_at_last;
      end
    end
    @(negedge clk);
    ev_valid = 1'b0; ev_last = 1'b0; rd_strobe = 1'b0;
    if (take) begin
      m_chg = chg;
      m_prs = prs & chg;
    end
  endtask

  task automatic read_one(input string req);
    chk(req, status_byte, model_head());
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (m_chg != 0) m_chg = m_chg & (m_chg - 1);
  endtask

  task automatic read_all(input string req);
    while (m_chg != 0) read_one(req);
    chk({req, " R3 empty byte"}, status_byte, 8'h00);
    chk({req, " R3 int released"}, int_n, 1'b1);
  endtask

  task automatic count_low(output int cnt);
    cnt = 0;
    while (int_n == 1'b0 && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [63:0] c, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 int_n after reset", int_n, 1'b1);
    chk("R10 byte after reset", status_byte, 8'h00);

    // R11: read of an empty register
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    chk("R11 byte", status_byte, 8'h00);
    chk("R11 int_n", int_n, 1'b1);

    // Full 64-key batch, reverse arrival, no timer
    aci_mode = 2'b00;
    c = '1;
    for (int i = 0; i < 64; i++) p[i] = (i % 3 == 0);
    send_batch(c, p, 1'b1, 1'b1, 1'b0);
    chk("R4 int low after commit", int_n, 1'b0);
    chk("R4 head after commit", status_byte, model_head());
    repeat (60) @(negedge clk);
    chk("R6 mode 00 keeps int low", int_n, 1'b0);
    read_all("R1 R2 full sweep");

    // R5: lockout while pending
    c = '0; c[5] = 1'b1; c[9] = 1'b1; p = '0; p[9] = 1'b1;
    send_batch(c, p, 1'b0, 1'b1, 1'b0);
    c = '0; c[1] = 1'b1; p = c;
    send_batch(c, p, 1'b0, 1'b0, 1'b0);
    chk("R5 locked batch dropped", status_byte, model_head());
    read_all("R5 readout");

    // R6 / R7: short timer, then read after release
    aci_mode = 2'b01;
    c = '0; c[3] = 1'b1; c[7] = 1'b1; c[12] = 1'b1; p = c;
    send_batch(c, p, 1'b1, 1'b1, 1'b0);
    count_low(cnt);
    chk("R6 short low cycles", cnt, SHORT);
    read_one("R7 read after release");
    chk("R7 int stays high", int_n, 1'b1);
    read_one("R7 read after release");
    chk("R7 int stays high", int_n, 1'b1);
    read_one("R7 read after release");
    chk("R7 empty", status_byte, 8'h00);

    // R6: long timer
    aci_mode = 2'b10;
    send_batch(c, p, 1'b0, 1'b1, 1'b0);
    count_low(cnt);
    chk("R6 long low cycles", cnt, LONG);
    read_all("R7 long readout");

    // R6: mode 11 disables timer
    aci_mode = 2'b11;
    send_batch(c, p, 1'b0, 1'b1, 1'b0);
    repeat (LONG + 10) @(negedge clk);
    chk("R6 mode 11 keeps int low", int_n, 1'b0);
    read_all("R6 mode 11 readout");

    // R8: replacement after release
    aci_mode = 2'b01;
    send_batch(c, p, 1'b0, 1'b1, 1'b0);
    count_low(cnt);
    read_one("R8 pop old");
    c = '0; c[2] = 1'b1; c[40] = 1'b1; p = '0; p[40] = 1'b1;
    send_batch(c, p, 1'b1, 1'b1, 1'b0);
    chk("R8 new head", status_byte, model_head());
    read_all("R8 new batch");

    // R8: commit and read strobe in the same cycle
    c = '0; c[3] = 1'b1; c[7] = 1'b1; c[12] = 1'b1; p = c;
    send_batch(c, p, 1'b0, 1'b1, 1'b0);
    count_low(cnt);
    read_one("R8 pop old before collision");
    c = '0; c[10] = 1'b1; c[20] = 1'b1; c[33] = 1'b1; p = '0; p[20] = 1'b1;
    send_batch(c, p, 1'b0, 1'b1, 1'b1);
    chk("R8 collision head", status_byte, {1'b1, 1'b0, 6'd10});
    chk("R8 collision int", int_n, 1'b0);
    read_all("R8 collision readout");

    // R9: repeated code, ready high
    aci_mode = 2'b00;
    @(negedge clk);
    ev_valid = 1'b1; ev_code = 6'd4; ev_press = 1'b1; ev_last = 1'b0;
    chk("R9 ready", ev_ready, 1'b1);
    @(negedge clk);
    ev_press = 1'b0; ev_last = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; ev_last = 1'b0;
    m_chg = '0; m_chg[4] = 1'b1; m_prs = '0;
    chk("R9 single event", status_byte, 8'h04);
    read_all("R9 readout");

    // Pattern sweep
    for (int s = 1; s <= 8; s++) begin
      c = '0; p = '0;
      for (int i = 0; i < 64; i++) begin
        c[i] = ((i * s + 3 * s) % 7) < 3;
        p[i] = ((i + s) % 2) == 1;
      end
      send_batch(c, p, s[0], 1'b1, 1'b0);
      chk("R4 sweep int", int_n, 1'b0);
      read_all("R1 R2 sweep");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule